// File: doc/BRIEF.md
# Block-Parallel Stochastic Signed Accumulating Adder

This block adds N signed stochastic products and produces the sum as a stochastic output stream. Each product term enters as two operands. Each operand has a sign bit and one bit per cycle of a unipolar magnitude stream. The full stream length is split into K blocks. K identical lanes each take one block, so the whole sum takes L accepted beats instead of K*L. The K*N operand pairs arrive in parallel on every accepted beat.

In each lane, a product is non-zero in a cycle only when both magnitude bits are 1. The sign of the product is positive when the two operand signs match and negative otherwise. Per beat, the lane counts its positive and negative product ones and adds the two counts into separate running totals. It then builds two candidate output streams from those totals:
- The positive candidate emits a 1 whenever the ones it has already emitted fall short of the positive net total.
- The negative candidate does the same against the negative net total.

After the L-th beat, the lane takes its sign from the two totals. The block then plays out the matching candidate stream over L cycles. All lanes play out together, each with its own sign.

A pulse on `start` opens a new block window. Operand beats are qualified by `in_valid`. Results appear under `out_valid`, and `done` marks the last output cycle.

Top module: `sc_blk_adder`

## Requirements
- R1: While reset is held and on leaving it, `out_valid` and `done` are 0, and no output phase begins until a start pulse has been followed by L accepted beats.
- R2: For pair j of lane k, operand bits sit at index k*N+j of each input bus. The product is 1 only when both magnitude bits are 1. It counts as positive when the two sign bits are equal and as negative when they differ.
- R3: After L accepted beats, `out_neg[k]` is 1 exactly when lane k's negative total is larger than its positive total. It holds that value through the whole output phase.
- R4: On beat b, the positive candidate bit is 1 when the ones it emitted on earlier beats number fewer than (positive total − negative total), with both totals including beat b. The negative candidate bit uses the mirrored difference. Each candidate emits at most one 1 per beat.
- R5: The output phase lasts exactly L cycles with `out_valid` high. `out_bits[k]` carries the chosen candidate of lane k, beat 0 first. `done` is high only in the last of those cycles.
- R6: `out_valid` rises in the cycle right after the L-th accepted beat.
- R7: A cycle with `in_valid` low does not advance or alter any lane. Idle cycles may fall between accepted beats.
- R8: `in_valid` is ignored outside an accumulation window (idle or output phase). It neither starts an output phase nor changes the stream being played out.
- R9: A start pulse, in any phase, clears every lane's totals and emitted-ones counts in the same cycle and opens a fresh window. An `in_valid` beat in the start cycle is not counted.
- R10: The totals never wrap. With every product positive and set for all L beats, the output is L ones with a non-negative sign, and the all-negative case gives L ones with `out_neg` set.
- R11: Lanes are independent: each lane's sign and stream depend only on the pairs of that lane.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst_n | input | 1 | Synchronous active-low reset |
| start | input | 1 | Opens a new accumulation window, clearing all lanes |
| in_valid | input | 1 | Qualifies one operand beat |
| a_sign | input | K*N | Sign bits of first operands, lane-major |
| a_mag | input | K*N | Magnitude stream bits of first operands |
| b_sign | input | K*N | Sign bits of second operands |
| b_mag | input | K*N | Magnitude stream bits of second operands |
| out_valid | output | 1 | High during the L-cycle output phase |
| out_bits | output | K | Current output stream bit of each lane |
| out_neg | output | K | Sign of each lane's sum (1 = negative) |
| done | output | 1 | High in the last output cycle |

## Verification
A fault in a lane's totals shows up first in the sign of that lane. If the totals stay on the same side of each other, the fault appears instead as a moved or missing 1 in the played-out stream. Both are visible one cycle after the L-th beat and are compared bit by bit against a model of the emission rule. A wrong beat counter or phase shows directly at the ports: `out_valid` rises early or late, the output phase has the wrong length, or `done` falls on the wrong cycle. Beats dropped or doubled around idle gaps, ignored-phase traffic or restarts shift every later stream bit, so a single output window exposes them.

// File: rtl/sc_blk_pkg.sv
// Shared types for the block-parallel stochastic adder.
// Assumes nothing beyond IEEE 1800-2017.
package sc_blk_pkg;

    // Controller phase: waiting, taking operand beats, playing out results.
    typedef enum logic [1:0] {
        PH_IDLE = 2'd0,
        PH_ACC  = 2'd1,
        PH_OUT  = 2'd2
    } phase_t;

endpackage

// File: rtl/sc_pair_count.sv
// Per-lane product former and split population counter.
// Forms N sign/magnitude products combinationally and counts positive
// and negative ones separately. Assumes N >= 1.
module sc_pair_count #(
    parameter int N = 4,
    localparam int PC_W = $clog2(N + 1)
) (
    input  logic [N-1:0]    sgn_a,
    input  logic [N-1:0]    mag_a,
    input  logic [N-1:0]    sgn_b,
    input  logic [N-1:0]    mag_b,
    output logic [PC_W-1:0] pos_cnt,
    output logic [PC_W-1:0] neg_cnt
);

    logic [N-1:0] prod_pos;
    logic [N-1:0] prod_neg;

    // One product per pair: AND of magnitudes, sign split by XNOR of signs.
    for (genvar j = 0; j < N; j++) begin : g_prod
        logic hit;
        assign hit         = mag_a[j] & mag_b[j];
        assign prod_pos[j] = hit & ~(sgn_a[j] ^ sgn_b[j]);
        assign prod_neg[j] = hit &  (sgn_a[j] ^ sgn_b[j]);
    end

    // Population count of both product vectors.
    always_comb begin
        pos_cnt = '0;
        neg_cnt = '0;
        for (int j = 0; j < N; j++) begin
            pos_cnt = pos_cnt + PC_W'(prod_pos[j]);
            neg_cnt = neg_cnt + PC_W'(prod_neg[j]);
        end
    end

endmodule

// File: rtl/sc_blk_ctrl.sv
// Phase controller shared by all lanes.
// Counts accepted beats up to L, then runs an L-cycle output phase.
// Start wins over in_valid in the same cycle. Assumes L >= 2.
module sc_blk_ctrl
    import sc_blk_pkg::*;
#(
    parameter int L = 16,
    localparam int BEAT_W = $clog2(L)
) (
    input  logic clk,
    input  logic rst_n,
    input  logic start,
    input  logic in_valid,
    output logic clr,
    output logic acc_en,
    output logic out_en,
    output logic out_last
);

    phase_t            phase;
    logic [BEAT_W-1:0] beat;
    logic              beat_end;

    assign beat_end = (beat == BEAT_W'(L - 1));
    assign clr      = start;
    assign acc_en   = (phase == PH_ACC) && in_valid && !start;
    assign out_en   = (phase == PH_OUT);
    assign out_last = out_en && beat_end;

    // Phase and beat counter sequencing.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase <= PH_IDLE;
            beat  <= '0;
        end else if (start) begin
            phase <= PH_ACC;
            beat  <= '0;
        end else begin
            case (phase)
                PH_ACC: if (in_valid) begin
                    beat  <= beat_end ? '0 : beat + 1'b1;
                    phase <= beat_end ? PH_OUT : PH_ACC;
                end
                PH_OUT: begin
                    beat  <= beat_end ? '0 : beat + 1'b1;
                    phase <= beat_end ? PH_IDLE : PH_OUT;
                end
                default: beat <= '0;
            endcase
        end
    end

endmodule

// File: rtl/sc_blk_lane.sv
// One bitstream block lane: positive/negative accumulators, count-tracking
// candidate stream generation, L-bit candidate buffers and sign selection.
// Assumes L >= 2 and that clr/acc_en/out_en come from one controller.
module sc_blk_lane #(
    parameter int N = 4,
    parameter int L = 16,
    localparam int PC_W  = $clog2(N + 1),
    localparam int ACC_W = $clog2(N * L + 1),
    localparam int CNT_W = $clog2(L + 1),
    localparam int DIF_W = ACC_W + 1
) (
    input  logic         clk,
    input  logic         rst_n,
    input  logic         clr,
    input  logic         acc_en,
    input  logic         out_en,
    input  logic [N-1:0] sgn_a,
    input  logic [N-1:0] mag_a,
    input  logic [N-1:0] sgn_b,
    input  logic [N-1:0] mag_b,
    output logic         out_bit,
    output logic         out_neg
);

    logic [PC_W-1:0]         pos_cnt;
    logic [PC_W-1:0]         neg_cnt;
    logic [ACC_W-1:0]        acc_p;
    logic [ACC_W-1:0]        acc_n;
    logic [ACC_W-1:0]        acc_p_nx;
    logic [ACC_W-1:0]        acc_n_nx;
    logic [CNT_W-1:0]        emit_p;
    logic [CNT_W-1:0]        emit_n;
    logic signed [DIF_W-1:0] net_pos;
    logic signed [DIF_W-1:0] net_neg;
    logic                    bit_p;
    logic                    bit_n;
    logic [L-1:0]            sr_p;
    logic [L-1:0]            sr_n;

    sc_pair_count #(.N(N)) u_cnt (
        .sgn_a   (sgn_a),
        .mag_a   (mag_a),
        .sgn_b   (sgn_b),
        .mag_b   (mag_b),
        .pos_cnt (pos_cnt),
        .neg_cnt (neg_cnt)
    );

    // Totals including the current beat, and the two net differences.
    always_comb begin
        acc_p_nx = acc_p + ACC_W'(pos_cnt);
        acc_n_nx = acc_n + ACC_W'(neg_cnt);
        net_pos  = $signed({1'b0, acc_p_nx}) - $signed({1'b0, acc_n_nx});
        net_neg  = $signed({1'b0, acc_n_nx}) - $signed({1'b0, acc_p_nx});
        bit_p    = net_pos > $signed({{(DIF_W - CNT_W){1'b0}}, emit_p});
        bit_n    = net_neg > $signed({{(DIF_W - CNT_W){1'b0}}, emit_n});
    end

    // Accumulators, emitted-ones counters and candidate buffers.
    always_ff @(posedge clk) begin
        if (!rst_n || clr) begin
            acc_p  <= '0;
            acc_n  <= '0;
            emit_p <= '0;
            emit_n <= '0;
            sr_p   <= '0;
            sr_n   <= '0;
        end else if (acc_en) begin
            acc_p  <= acc_p_nx;
            acc_n  <= acc_n_nx;
            emit_p <= emit_p + CNT_W'(bit_p);
            emit_n <= emit_n + CNT_W'(bit_n);
            sr_p   <= {sr_p[L-2:0], bit_p};
            sr_n   <= {sr_n[L-2:0], bit_n};
        end else if (out_en) begin
            sr_p   <= {sr_p[L-2:0], 1'b0};
            sr_n   <= {sr_n[L-2:0], 1'b0};
        end
    end

    assign out_neg = (acc_n > acc_p);
    assign out_bit = out_neg ? sr_n[L-1] : sr_p[L-1];

endmodule

// File: rtl/sc_blk_adder.sv
// Top: K parallel lanes under one phase controller.
// Lane k owns bits k*N .. k*N+N-1 of each operand bus.
// Assumes K >= 1, N >= 1, L >= 2.
module sc_blk_adder #(
    parameter int K = 4,
    parameter int N = 4,
    parameter int L = 16,
    localparam int KN = K * N
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          start,
    input  logic          in_valid,
    input  logic [KN-1:0] a_sign,
    input  logic [KN-1:0] a_mag,
    input  logic [KN-1:0] b_sign,
    input  logic [KN-1:0] b_mag,
    output logic          out_valid,
    output logic [K-1:0]  out_bits,
    output logic [K-1:0]  out_neg,
    output logic          done
);

    logic clr;
    logic acc_en;
    logic out_en;
    logic out_last;

    sc_blk_ctrl #(.L(L)) u_ctrl (
        .clk      (clk),
        .rst_n    (rst_n),
        .start    (start),
        .in_valid (in_valid),
        .clr      (clr),
        .acc_en   (acc_en),
        .out_en   (out_en),
        .out_last (out_last)
    );

    for (genvar k = 0; k < K; k++) begin : g_lane
        sc_blk_lane #(.N(N), .L(L)) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .clr     (clr),
            .acc_en  (acc_en),
            .out_en  (out_en),
            .sgn_a   (a_sign[k*N +: N]),
            .mag_a   (a_mag[k*N +: N]),
            .sgn_b   (b_sign[k*N +: N]),
            .mag_b   (b_mag[k*N +: N]),
            .out_bit (out_bits[k]),
            .out_neg (out_neg[k])
        );
    end

    assign out_valid = out_en;
    assign done      = out_last;

endmodule

// File: rtl/sc_blk_adder_chk.sv
// Port-level protocol checker for sc_blk_adder, bound to every instance.
// Tracks the length of the current output run with a counter.
module sc_blk_adder_chk #(
    parameter int K = 4,
    parameter int L = 16,
    localparam int RUN_W = $clog2(L + 1)
) (
    input logic         clk,
    input logic         rst_n,
    input logic         start,
    input logic         in_valid,
    input logic         out_valid,
    input logic         done,
    input logic [K-1:0] out_neg
);

    logic [RUN_W-1:0] run;

    // Consecutive output-phase cycles seen so far.
    always_ff @(posedge clk) begin
        if (!rst_n || !out_valid) run <= '0;
        else                      run <= run + 1'b1;
    end

    // R5
    done_in_out_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |-> out_valid && (run == RUN_W'(L - 1)));

    // R5
    out_run_len_chk: assert property (@(posedge clk) disable iff (!rst_n)
        out_valid |-> (run < RUN_W'(L)));

    // R5
    done_ends_chk: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !out_valid);

    // R3
    sign_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !done) |=> $stable(out_neg));

    // R6
    out_after_beat_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!out_valid && !start && !in_valid) |=> !out_valid);

endmodule

bind sc_blk_adder sc_blk_adder_chk #(.K(K), .L(L)) u_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .start     (start),
    .in_valid  (in_valid),
    .out_valid (out_valid),
    .done      (done),
    .out_neg   (out_neg)
);

// File: tb/sc_blk_adder_tb.sv
// Self-checking bench: seeded random blocks plus directed corners.
module sc_blk_adder_tb;

    localparam int K  = 4;
    localparam int N  = 4;
    localparam int L  = 16;
    localparam int KN = K * N;

    logic          clk = 1'b0;
    logic          rst_n = 1'b0;
    logic          start = 1'b0;
    logic          in_valid = 1'b0;
    logic [KN-1:0] a_sign = '0, a_mag = '0, b_sign = '0, b_mag = '0;
    logic          out_valid;
    logic [K-1:0]  out_bits;
    logic [K-1:0]  out_neg;
    logic          done;

    int tests = 0;
    int fails = 0;
    int cyc   = 0;

    logic [KN-1:0] st_sa [L];
    logic [KN-1:0] st_ma [L];
    logic [KN-1:0] st_sb [L];
    logic [KN-1:0] st_mb [L];
    logic [L-1:0]  exp_seq [K];
    logic [K-1:0]  exp_neg;

    sc_blk_adder #(.K(K), .N(N), .L(L)) u_dut (
        .clk(clk), .rst_n(rst_n), .start(start), .in_valid(in_valid),
        .a_sign(a_sign), .a_mag(a_mag), .b_sign(b_sign), .b_mag(b_mag),
        .out_valid(out_valid), .out_bits(out_bits), .out_neg(out_neg),
        .done(done)
    );

    always #5 clk = ~clk;

    task automatic finish_run();
        $display("  [TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    always @(posedge clk) begin
        cyc <= cyc + 1;
        if (cyc > 150000) begin
            fails++;
            tests++;
            $display("FAIL watchdog: actual=%0d cycles expected<150000", cyc);
            finish_run();
        end
    end

    task automatic chk(input bit ok, input string req, input longint act, input longint exp);
        tests++;
        if (!ok) begin
            fails++;
            $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
        end
    endtask

    // Expected signs and streams from the requirements (R2, R3, R4).
    task automatic model();
        for (int k = 0; k < K; k++) begin
            int ap = 0, an = 0, cp = 0, cn = 0;
            logic [L-1:0] sp = '0, sn = '0;
            for (int b = 0; b < L; b++) begin
                for (int j = 0; j < N; j++) begin
                    int i = k * N + j;
                    if (st_ma[b][i] && st_mb[b][i]) begin
                        if (st_sa[b][i] == st_sb[b][i]) ap++;
                        else an++;
                    end
                end
                if (ap - an > cp) begin sp[b] = 1'b1; cp++; end
                if (an - ap > cn) begin sn[b] = 1'b1; cn++; end
            end
            exp_neg[k] = (an > ap);
            exp_seq[k] = exp_neg[k] ? sn : sp;
        end
    endtask

    // mode 0 random, 1 all positive, 2 all negative, 3 no magnitude, 4 dense random
    task automatic gen(input int mode);
        for (int b = 0; b < L; b++) begin
            st_sa[b] = {$urandom, $urandom};
            st_sb[b] = {$urandom, $urandom};
            st_ma[b] = {$urandom, $urandom};
            st_mb[b] = {$urandom, $urandom};
            case (mode)
                1: begin st_ma[b] = '1; st_mb[b] = '1; st_sb[b] = st_sa[b]; end
                2: begin st_ma[b] = '1; st_mb[b] = '1; st_sb[b] = ~st_sa[b]; end
                3: begin st_ma[b] = '0; end
                4: begin st_ma[b] = st_ma[b] | {$urandom, $urandom}; end
                default: ;
            endcase
        end
        model();
    endtask

    task automatic drive_rand();
        a_sign = {$urandom, $urandom}; a_mag = {$urandom, $urandom};
        b_sign = {$urandom, $urandom}; b_mag = {$urandom, $urandom};
    endtask

    // Start, feed L beats (optional idle gaps), check the output window.
    task automatic run_block(input int gap_pct, input bit junk_out, input string tag);
        logic [L-1:0] got [K];
        int done_err = 0, val_err = 0;
        logic [K-1:0] neg_seen = '0;
        start = 1'b1; in_valid = 1'b1; drive_rand();
        @(negedge clk);
        start = 1'b0;
        for (int b = 0; b < L; b++) begin
            while (($urandom % 100) < gap_pct) begin
                in_valid = 1'b0; drive_rand();
                @(negedge clk);
                if (out_valid) val_err++;
            end
            in_valid = 1'b1;
            a_sign = st_sa[b]; a_mag = st_ma[b]; b_sign = st_sb[b]; b_mag = st_mb[b];
            @(negedge clk);
            if (out_valid && b != L - 1) val_err++;
        end
        // R6: output window opens right after the L-th beat
        chk(out_valid === 1'b1 && val_err == 0, {"R6 ", tag}, {out_valid, 8'(val_err)}, 1);
        for (int i = 0; i < L; i++) begin
            in_valid = junk_out;
            drive_rand();
            if (!out_valid) val_err++;
            if (done !== (i == L - 1)) done_err++;
            if (i == 0) neg_seen = out_neg;
            for (int k = 0; k < K; k++) got[k][i] = out_bits[k];
            @(negedge clk);
        end
        in_valid = 1'b0;
        // R5: exactly L output cycles, done on the last
        chk(val_err == 0 && done_err == 0 && out_valid === 1'b0, {"R5 ", tag},
            {8'(val_err), 8'(done_err)}, 0);
        // R3 sign per lane, R11 independent lanes
        chk(neg_seen === exp_neg, {"R3 R11 ", tag}, neg_seen, exp_neg);
        for (int k = 0; k < K; k++)
            // R4 R2 stream per lane (R8 when junk_out)
            chk(got[k] === exp_seq[k], {"R4 R2 R8 ", tag}, got[k], exp_seq[k]);
    endtask

    initial begin
        void'($urandom(32'h5eed_1234));
        repeat (3) @(negedge clk);
        // R1: reset state
        chk(out_valid === 1'b0 && done === 1'b0, "R1 reset", {out_valid, done}, 0);
        rst_n = 1'b1;
        in_valid = 1'b1;
        repeat (L + 2) begin
            drive_rand();
            @(negedge clk);
            if (out_valid !== 1'b0) chk(1'b0, "R1 R8 idle", out_valid, 0);
        end
        chk(out_valid === 1'b0, "R1 R8 idle beats ignored", out_valid, 0);
        in_valid = 1'b0;

        // R10: saturating corners
        gen(1); run_block(0, 1'b0, "all positive R10");
        gen(2); run_block(0, 1'b0, "all negative R10");
        gen(3); run_block(0, 1'b0, "zero magnitude");

        // R7: idle gaps between beats
        gen(0); run_block(40, 1'b0, "gaps R7");
        // R8: beats during output are ignored
        gen(4); run_block(0, 1'b1, "junk in output R8");

        // R9: restart mid-window discards earlier beats
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int b = 0; b < L / 2; b++) begin
            in_valid = 1'b1; a_mag = '1; b_mag = '1; a_sign = '0; b_sign = '0;
            @(negedge clk);
        end
        gen(0); run_block(10, 1'b0, "restart R9");

        // R9: restart during output phase stops it
        gen(1);
        start = 1'b1; @(negedge clk); start = 1'b0;
        for (int b = 0; b < L; b++) begin
            in_valid = 1'b1; a_mag = '1; b_mag = '1; a_sign = '0; b_sign = '0;
            @(negedge clk);
        end
        in_valid = 1'b0;
        repeat (3) @(negedge clk);
        start = 1'b1; @(negedge clk); start = 1'b0;
        chk(out_valid === 1'b0, "R9 start aborts output", out_valid, 0);

        // Random blocks
        for (int r = 0; r < 20; r++) begin
            gen((r % 3 == 0) ? 4 : 0);
            run_block(r % 4 * 10, r[0], "random");
        end
        finish_run();
    end

endmodule